// File: doc/BRIEF.md
# Eight-Channel Countdown Timer Bank

This block holds a set of independent down-counters behind one APB3 slave port. Each channel has a reload value, a live count, a three-bit control word, a read-to-clear interrupt register and a masked status bit. A shared region at the top of the address space gives combined raw and masked status, a clear for all channels at once, and a fixed version word. The counters advance on a shared timer tick, which is a clock enable in the bus clock domain.

A channel runs in one of two modes. In periodic mode it restarts from its programmed reload value. In free-running mode it restarts from the all-ones value. The first tick after the channel is enabled loads the start value, and each later tick counts down by one. The tick that finds the count at zero is the expiry: it latches the channel's raw interrupt bit and loads the start value again. The raw bit latches even while the channel's mask is set. The interrupt output shows raw status with the masked channels removed, and software reads it to decide which channel to service.

Top module: `tmr_bank`

## Requirements
- R1: PREADY is always 1 and PSLVERR is always 0. Unmapped addresses (for example 0x02 or 0xB0) read as zero. Writes to read-only registers (the count and the version word) have no effect.
- R2: Channel n has its registers at n*0x14 plus an offset: 0x00 reload (read/write), 0x04 live count (read-only), 0x08 control, 0x0C interrupt clear and 0x10 status (bit 0 = masked pending). Values narrower than 32 bits read back zero-extended.
- R3: Control bit 0 enables the channel. Bit 1 selects the mode (1 = periodic, 0 = free-running). Bit 2 masks the channel's interrupt (1 = masked).
- R4: After enable goes from 0 to 1, the first tick loads the start value: the reload value in periodic mode, all-ones in free-running mode. The count does not change between ticks, and it holds while the channel is disabled.
- R5: Each tick after the start decrements the count by one. A tick that finds the count at zero sets the raw bit and reloads: the reload value in periodic mode, all-ones in free-running mode.
- R6: A write to the reload register while the channel is enabled is ignored.
- R7: The raw bit sets on expiry even while the channel is masked. irq[n] and the status bit equal the raw bit AND NOT the mask bit, so clearing the mask exposes a pending expiry.
- R8: Reading a channel's clear register returns zero and clears that channel's raw bit.
- R9: Global registers: 0xA0 gives masked status, 0xA8 gives raw status and 0xAC gives the VERSION parameter, each with bit n for channel n. Reading 0xA4 returns zero and clears every channel's raw bit.
- R10: Channels operate independently. The count and the raw bit of one channel are unaffected by the programming or expiry of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timer clock enable, one count step per high cycle |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB direction, 1 = write |
| paddr | input | AW | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always high |
| pslverr | output | 1 | Always low |
| irq | output | NUM_CH | Per-channel masked interrupt |

## Verification
The assertions assume that the tick input is the only thing that moves a count, and that a global clear read issued when no tick is present leaves all raw bits at zero. They also assume that the bus follows the APB setup-then-access order, with psel held through penable. The stimulus keeps tick low during every bus transfer and raises it only in isolated pulses between transfers. As a result, no expiry ever coincides with a clear read, and every count can be predicted by counting pulses. The bench uses an 8-bit counter width so that free-running wraparound is reached in a few hundred ticks.

// File: rtl/tmr_bank_pkg.sv
package tmr_bank_pkg;
  localparam int CH_STRIDE = 20;
  localparam logic [4:0] OFF_LOAD = 5'd0;
  localparam logic [4:0] OFF_CNT  = 5'd4;
  localparam logic [4:0] OFF_CTRL = 5'd8;
  localparam logic [4:0] OFF_EOI  = 5'd12;
  localparam logic [4:0] OFF_STAT = 5'd16;
  localparam logic [7:0] GLB_STAT = 8'hA0;
  localparam logic [7:0] GLB_EOI  = 8'hA4;
  localparam logic [7:0] GLB_RAW  = 8'hA8;
  localparam logic [7:0] GLB_VER  = 8'hAC;

  typedef struct packed {
    logic msk;
    logic per;
    logic en;
  } tmr_ctrl_t;
endpackage

// File: rtl/tmr_apb_dec.sv
module tmr_apb_dec
  import tmr_bank_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int AW     = 8
) (
  input  logic [AW-1:0]     addr,
  output logic [NUM_CH-1:0] ch_sel,
  output logic [4:0]        off,
  output logic              glb_hit
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_win
    localparam int LO = g * CH_STRIDE;
    localparam int HI = (g + 1) * CH_STRIDE;
    assign ch_sel[g] = (int'(addr) >= LO) && (int'(addr) < HI);
  end

  always_comb begin
    off = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (ch_sel[i]) off = 5'(int'(addr) - i * CH_STRIDE);
    end
  end

  assign glb_hit = (addr == AW'(GLB_STAT)) || (addr == AW'(GLB_EOI)) ||
                   (addr == AW'(GLB_RAW))  || (addr == AW'(GLB_VER));
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_bank_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_load,
  input  logic          wr_ctrl,
  input  logic          rd_eoi,
  input  logic          clr_all,
  input  logic [CW-1:0] wdata,
  input  tmr_ctrl_t     wctrl,
  output logic [CW-1:0] load_o,
  output logic [CW-1:0] cnt_o,
  output tmr_ctrl_t     ctrl_o,
  output logic          raw_o
);
  localparam logic [CW-1:0] ALL_ONES = '1;

  logic [CW-1:0] load_q, cnt_q, cnt_d, wrap_val;
  tmr_ctrl_t     ctrl_q;
  logic          pend_q, pend_d, raw_q, raw_d;
  logic          load_ce, cnt_ce, expire;

  // Next-state logic
  always_comb begin
    load_ce  = wr_load && !ctrl_q.en;
    cnt_ce   = tick && ctrl_q.en;
    wrap_val = ctrl_q.per ? load_q : ALL_ONES;
    cnt_d    = cnt_q;
    expire   = 1'b0;
    pend_d   = pend_q;
    if (cnt_ce) begin
      if (pend_q) begin
        cnt_d  = wrap_val;
        pend_d = 1'b0;
      end else if (cnt_q == '0) begin
        cnt_d  = wrap_val;
        expire = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
    if (wr_ctrl && wctrl.en && !ctrl_q.en) pend_d = 1'b1;
    else if (!ctrl_q.en)                   pend_d = 1'b0;
    raw_d = raw_q;
    if (rd_eoi || clr_all) raw_d = 1'b0;
    if (expire)            raw_d = 1'b1;
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= '0;
      cnt_q  <= '0;
      ctrl_q <= '0;
      pend_q <= 1'b0;
      raw_q  <= 1'b0;
    end else begin
      if (load_ce) load_q <= wdata;
      if (cnt_ce)  cnt_q  <= cnt_d;
      if (wr_ctrl) ctrl_q <= wctrl;
      pend_q <= pend_d;
      raw_q  <= raw_d;
    end
  end

  assign load_o = load_q;
  assign cnt_o  = cnt_q;
  assign ctrl_o = ctrl_q;
  assign raw_o  = raw_q;
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_bank_pkg::*;
#(
  parameter int          NUM_CH  = 8,
  parameter int          CW      = 32,
  parameter int          AW      = 8,
  parameter logic [31:0] VERSION = 32'h0001_0200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [AW-1:0]     paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr,
  output logic [NUM_CH-1:0] irq
);
  logic                   acc, wr, rd, glb_hit, clr_all;
  logic [NUM_CH-1:0]      ch_sel, raw_vec, mask_vec, en_vec;
  logic [4:0]             off;
  logic [CW-1:0]          load_a [NUM_CH];
  logic [CW-1:0]          cnt_a  [NUM_CH];
  tmr_ctrl_t              ctrl_a [NUM_CH];
  logic [NUM_CH*CW-1:0]   cnt_flat;
  logic [31:0]            rdata;

  assign acc     = psel && penable;
  assign wr      = acc && pwrite;
  assign rd      = acc && !pwrite;
  assign clr_all = rd && (paddr == AW'(GLB_EOI));

  tmr_apb_dec #(.NUM_CH(NUM_CH), .AW(AW)) u_dec (
    .addr    (paddr),
    .ch_sel  (ch_sel),
    .off     (off),
    .glb_hit (glb_hit)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    tmr_chan #(.CW(CW)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .wr_load (wr && ch_sel[g] && (off == OFF_LOAD)),
      .wr_ctrl (wr && ch_sel[g] && (off == OFF_CTRL)),
      .rd_eoi  (rd && ch_sel[g] && (off == OFF_EOI)),
      .clr_all (clr_all),
      .wdata   (pwdata[CW-1:0]),
      .wctrl   (tmr_ctrl_t'(pwdata[2:0])),
      .load_o  (load_a[g]),
      .cnt_o   (cnt_a[g]),
      .ctrl_o  (ctrl_a[g]),
      .raw_o   (raw_vec[g])
    );
    assign mask_vec[g]               = ctrl_a[g].msk;
    assign en_vec[g]                 = ctrl_a[g].en;
    assign cnt_flat[g*CW +: CW]      = cnt_a[g];
  end

  assign irq = raw_vec & ~mask_vec;

  // Read data multiplexer
  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (ch_sel[i]) begin
        case (off)
          OFF_LOAD: rdata[CW-1:0] = load_a[i];
          OFF_CNT:  rdata[CW-1:0] = cnt_a[i];
          OFF_CTRL: rdata[2:0]    = ctrl_a[i];
          OFF_STAT: rdata[0]      = irq[i];
          default:  rdata = '0;
        endcase
      end
    end
    if (glb_hit) begin
      if (paddr == AW'(GLB_STAT)) rdata[NUM_CH-1:0] = irq;
      if (paddr == AW'(GLB_RAW))  rdata[NUM_CH-1:0] = raw_vec;
      if (paddr == AW'(GLB_VER))  rdata = VERSION;
    end
  end

  assign prdata  = rdata;
  assign pready  = 1'b1;
  assign pslverr = 1'b0;
endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk
  import tmr_bank_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CW     = 32,
  parameter int AW     = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 tick,
  input logic                 psel,
  input logic                 penable,
  input logic                 pwrite,
  input logic [AW-1:0]        paddr,
  input logic                 pready,
  input logic                 pslverr,
  input logic [NUM_CH-1:0]    raw_vec,
  input logic [NUM_CH-1:0]    en_vec,
  input logic [NUM_CH*CW-1:0] cnt_flat
);
  // R1
  apb_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pready && !pslverr);

  // R4
  cnt_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_flat));

  // R9
  glb_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable && !pwrite && paddr == AW'(GLB_EOI) && !tick) |=> (raw_vec == '0));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ck
    // R5
    raw_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !raw_vec[g]) |=> !raw_vec[g]);

    // R4
    off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_vec[g] |=> $stable(cnt_flat[g*CW +: CW]));
  end
endmodule

bind tmr_bank tmr_bank_chk #(.NUM_CH(NUM_CH), .CW(CW), .AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .psel     (psel),
  .penable  (penable),
  .pwrite   (pwrite),
  .paddr    (paddr),
  .pready   (pready),
  .pslverr  (pslverr),
  .raw_vec  (raw_vec),
  .en_vec   (en_vec),
  .cnt_flat (cnt_flat)
);

// File: tb/tmr_bank_tb.sv
`timescale 1ns/1ps
module tmr_bank_tb;
  localparam int          NCH = 8;
  localparam int          TCW = 8;
  localparam logic [31:0] VER = 32'h0001_0200;

  logic clk, rst_n, tick, psel, penable, pwrite, pready, pslverr;
  logic [7:0] paddr;
  logic [31:0] pwdata, prdata;
  logic [NCH-1:0] irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic [31:0] m_exp;
  string       m_tag;

  tmr_bank #(.NUM_CH(NCH), .CW(TCW), .AW(8), .VERSION(VER)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .pslverr(pslverr), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: compares read data late in the access phase
  always @(negedge clk) begin
    #4;
    if (psel && penable && !pwrite && exp_q.size() > 0) begin
      m_exp = exp_q.pop_front();
      m_tag = tag_q.pop_front();
      chk(prdata === m_exp, m_tag, prdata, m_exp);
    end
  end

  task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd_exp(input logic [7:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic tk(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 0; tick = 0; psel = 0; penable = 0; pwrite = 0; paddr = '0; pwdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(irq == '0, "reset irq R7", 32'(irq), 0);
    rd_exp(8'h04, 0, "reset count R2");
    rd_exp(8'h08, 0, "reset ctrl R3");
    rd_exp(8'hA8, 0, "reset raw R9");
    rd_exp(8'hAC, VER, "version R9");

    // R1 bus behaviour
    chk(pready && !pslverr, "R1 ready/err", {30'd0, pready, pslverr}, 32'h2);
    rd_exp(8'hB0, 0, "R1 unmapped B0");
    rd_exp(8'h02, 0, "R1 unmapped 02");
    apb_wr(8'hAC, 32'hDEAD_BEEF);
    rd_exp(8'hAC, VER, "R1 version write ignored");
    apb_wr(8'h04, 32'h55);
    rd_exp(8'h04, 0, "R1 count write ignored");

    // R2 R3 R4 R5 periodic on channel 0
    apb_wr(8'h00, 32'd3);
    rd_exp(8'h00, 3, "R2 reload readback");
    apb_wr(8'h08, 32'h3);
    rd_exp(8'h08, 3, "R3 ctrl readback");
    rd_exp(8'h04, 0, "R4 no load before tick");
    tk(1);
    rd_exp(8'h04, 3, "R4 periodic start");
    tk(3);
    rd_exp(8'h04, 0, "R5 count down to zero");
    rd_exp(8'h10, 0, "R5 no expiry yet");
    tk(1);
    rd_exp(8'h04, 3, "R5 periodic reload");
    rd_exp(8'h10, 1, "R7 status pending");
    chk(irq == 8'h01, "R7 irq0", 32'(irq), 32'h1);
    rd_exp(8'hA0, 1, "R9 masked combined");
    rd_exp(8'hA8, 1, "R9 raw combined");

    // R6 reload ignored while enabled
    apb_wr(8'h00, 32'd9);
    rd_exp(8'h00, 3, "R6 reload write while enabled");

    // R8 channel clear
    rd_exp(8'h0C, 0, "R8 clear reads zero");
    rd_exp(8'h10, 0, "R8 status cleared");
    chk(irq == 8'h00, "R8 irq cleared", 32'(irq), 0);

    // R4 hold while disabled
    apb_wr(8'h08, 32'h2);
    tk(5);
    rd_exp(8'h04, 3, "R4 hold while disabled");

    // R5 R7 free-running, masked, channel 1
    apb_wr(8'h1C, 32'h5);
    tk(1);
    rd_exp(8'h18, 32'hFF, "R4 free-run start all-ones");
    tk(255);
    rd_exp(8'h18, 0, "R5 free-run reaches zero");
    tk(1);
    rd_exp(8'h18, 32'hFF, "R5 free-run reload all-ones");
    rd_exp(8'hA8, 32'h2, "R7 raw set while masked");
    rd_exp(8'hA0, 0, "R7 masked combined zero");
    rd_exp(8'h24, 0, "R7 status masked");
    chk(irq == 8'h00, "R7 irq masked", 32'(irq), 0);
    apb_wr(8'h1C, 32'h1);
    chk(irq == 8'h02, "R7 unmask exposes", 32'(irq), 32'h2);
    rd_exp(8'hA0, 32'h2, "R7 masked combined after unmask");

    // R10 independence
    rd_exp(8'h04, 3, "R10 ch0 unaffected");

    // R9 global clear
    apb_wr(8'h08, 32'h3);
    tk(5);
    rd_exp(8'hA8, 32'h3, "R9 two pending");
    rd_exp(8'hA4, 0, "R9 global clear reads zero");
    rd_exp(8'hA8, 0, "R9 all cleared");
    chk(irq == 8'h00, "R9 irq cleared", 32'(irq), 0);

    // R10 last channel
    apb_wr(8'h8C, 32'd1);
    apb_wr(8'h94, 32'h3);
    tk(3);
    chk(irq == 8'h80, "R10 only ch7 expires", 32'(irq), 32'h80);
    rd_exp(8'h90, 1, "R10 ch7 count reload");

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule